// File: doc/BRIEF.md
# Multi-Lane Serial Flash Command Sequencer

This block runs one complete command against a serial flash device: it sends an opcode, then a 3-byte or 4-byte address, then an optional run of dummy clocks, and then moves a programmed number of data bytes in or out. Each of the opcode, address and data phases can use one, two or four I/O lanes. The lane count for each phase comes from a small set of configuration registers, with separate address and data settings for reads and for writes. A single instruction-width setting applies to both directions. When that setting selects more than one lane, it also sets the width of the address and data phases.

A client loads the configuration with `cfgWe` while the sequencer is idle. It then pulses `start` with the direction, the address, the byte count and, for writes, the outgoing bytes. The sequencer produces the serial clock and chip select and drives the lanes through per-lane output enables. Each received byte is returned with a one-cycle valid strobe. `done` is pulsed once after chip select has been released. The serial clock runs at half the system clock and idles low. Lanes change while the serial clock is low, and incoming lanes are sampled at the end of the high half.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, the read opcode is 0x03, the write opcode is 0x02, every width code is 0, the address length is 3 bytes and there are no dummy clocks. `csN` is high, and `sclk`, `ioOe`, `busy`, `done` and `rdValid` are low.
- R2: Width codes map to lanes as follows: 0 gives one lane, 1 gives two lanes, 2 gives four lanes. Outgoing bits leave MSB first. A single lane drives `ioOut[0]` and receives on `ioIn[1]`. Dual mode uses lanes 1:0 with the more significant bit on lane 1. Quad mode uses lanes 3:0, sending bits 7:4 of a byte before bits 3:0. `ioOe` is 0001, 0011 or 1111 on the lanes being driven.
- R3: The opcode phase always uses the shared instruction width `cfgInstWidth`, for both reads and writes. With a code of 0, the opcode goes out serially on lane 0 whatever the address and data widths are.
- R4: When the instruction width code is nonzero, the address and data phases use the same lane count, and the per-direction address and data width fields are ignored.
- R5: The address phase sends `addr[23:0]` when `cfgAddr4Byte` is 0 and `addr[31:0]` when it is 1, MSB first. The width code comes from the read or the write register set, according to `isWrite`.
- R6: The dummy phase lasts `cfgDummyCycles` serial clocks (0 to 15), and `ioOe` is 0 throughout it.
- R7: On a read, `numBytes` bytes (1 to MAX_BYTES) are received MSB first with every lane tristated. Each byte appears on `rdByte` with `rdValid` high for exactly one cycle.
- R8: On a write, byte k is taken from `wrData[8k+7:8k]`, starting with k = 0, and is driven on the data lane count.
- R9: `csN` stays low for exactly two system clocks per serial clock of the command. `sclk` is low whenever `csN` is high. `done` is high for exactly one cycle, which is the first cycle after `csN` rises.
- R10: A `start` pulse while `busy` is high is ignored. It changes neither the command in progress nor the later bus activity.
- R11: `cfgWe` is ignored while `busy` is high. Configuration changes only from a write made while the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Load all configuration fields (idle only) |
| cfgRdOpcode | input | 8 | Read command opcode |
| cfgWrOpcode | input | 8 | Write command opcode |
| cfgInstWidth | input | 2 | Shared instruction width code |
| cfgRdAddrWidth | input | 2 | Read address width code |
| cfgRdDataWidth | input | 2 | Read data width code |
| cfgWrAddrWidth | input | 2 | Write address width code |
| cfgWrDataWidth | input | 2 | Write data width code |
| cfgAddr4Byte | input | 1 | 1 selects a 4-byte address |
| cfgDummyCycles | input | DUMMY_W | Dummy serial clocks |
| start | input | 1 | Begin a command (single-cycle strobe) |
| isWrite | input | 1 | Command direction, 1 for write |
| addr | input | 32 | Flash address |
| numBytes | input | CNT_W | Data byte count, 1 to MAX_BYTES |
| wrData | input | 8*MAX_BYTES | Outgoing bytes, byte 0 in the low bits |
| ioIn | input | 4 | Lane input values |
| sclk | output | 1 | Serial clock |
| csN | output | 1 | Active-low chip select |
| ioOut | output | 4 | Lane output values |
| ioOe | output | 4 | Per-lane output enables |
| rdByte | output | 8 | Last received byte |
| rdValid | output | 1 | One-cycle strobe for `rdByte` |
| done | output | 1 | One-cycle command completion pulse |
| busy | output | 1 | High from the cycle after `start` through `done` |

## Verification
A `start` seen at one clock edge lowers `csN` in the very next cycle. Each serial clock then takes two cycles, low then high. The lane values for serial beat n therefore hold in cycle 2n+2 after the start edge, and read bits are sampled at the edge that closes that cycle. `rdValid` rises in the cycle after the last beat of its byte, and `done` comes one cycle after the final beat, together with `csN` high. The bench samples on the falling clock edge. It logs the lanes whenever `sclk` has just risen and presents read bits while `sclk` is low. It then rebuilds every opcode, address and data byte from that log, using beat offsets it computes itself from the configuration.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_ADDR,
    ST_DUMMY,
    ST_DATA,
    ST_DONE
  } seqStateT;

  // strobes from the controller to the datapath
  typedef struct packed {
    logic       loadOp;
    logic       loadAddr;
    logic       loadData;
    logic       advance;
    logic       sample;
    logic       byteEnd;
    logic       drive;
    logic [1:0] laneCode;
  } dpStrobeT;

  // log2 of the lane count for a width code
  function automatic logic [1:0] laneShift(input logic [1:0] code);
    case (code)
      2'd0:    return 2'd0;
      2'd1:    return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

  function automatic logic [3:0] laneMask(input logic [1:0] code);
    case (code)
      2'd0:    return 4'b0001;
      2'd1:    return 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

endpackage

// File: rtl/fcs_cfg.sv
module fcs_cfg #(
  parameter int DUMMY_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busy,
  input  logic               cfgWe,
  input  logic [7:0]         rdOpIn,
  input  logic [7:0]         wrOpIn,
  input  logic [1:0]         instIn,
  input  logic [1:0]         rdAddrIn,
  input  logic [1:0]         rdDataIn,
  input  logic [1:0]         wrAddrIn,
  input  logic [1:0]         wrDataIn,
  input  logic               addr4In,
  input  logic [DUMMY_W-1:0] dummyIn,
  output logic [7:0]         rdOp,
  output logic [7:0]         wrOp,
  output logic [1:0]         instWidth,
  output logic [1:0]         rdAddrWidth,
  output logic [1:0]         rdDataWidth,
  output logic [1:0]         wrAddrWidth,
  output logic [1:0]         wrDataWidth,
  output logic               addr4,
  output logic [DUMMY_W-1:0] dummyCycles
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdOp        <= 8'h03;
      wrOp        <= 8'h02;
      instWidth   <= 2'd0;
      rdAddrWidth <= 2'd0;
      rdDataWidth <= 2'd0;
      wrAddrWidth <= 2'd0;
      wrDataWidth <= 2'd0;
      addr4       <= 1'b0;
      dummyCycles <= '0;
    end else if (cfgWe && !busy) begin
      rdOp        <= rdOpIn;
      wrOp        <= wrOpIn;
      instWidth   <= instIn;
      rdAddrWidth <= rdAddrIn;
      rdDataWidth <= rdDataIn;
      wrAddrWidth <= wrAddrIn;
      wrDataWidth <= wrDataIn;
      addr4       <= addr4In;
      dummyCycles <= dummyIn;
    end
  end

  a_r11_cfg_locked: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable({rdOp, wrOp, instWidth, rdAddrWidth, rdDataWidth,
                      wrAddrWidth, wrDataWidth, addr4, dummyCycles}));

endmodule

// File: rtl/fcs_ctrl.sv
module fcs_ctrl
  import fcs_pkg::*;
#(
  parameter int MAX_BYTES = 4,
  parameter int DUMMY_W   = 4,
  localparam int CNT_W    = $clog2(MAX_BYTES + 1),
  localparam int IDX_W    = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               isWrite,
  input  logic [CNT_W-1:0]   numBytes,
  input  logic [1:0]         instWidth,
  input  logic [1:0]         rdAddrWidth,
  input  logic [1:0]         rdDataWidth,
  input  logic [1:0]         wrAddrWidth,
  input  logic [1:0]         wrDataWidth,
  input  logic               addr4,
  input  logic [DUMMY_W-1:0] dummyCycles,
  output logic               sclk,
  output logic               csN,
  output logic               busy,
  output logic               done,
  output dpStrobeT           strobe,
  output logic [IDX_W-1:0]   byteSel,
  output seqStateT           stateOut
);

  localparam int BEAT_W = (DUMMY_W > 6) ? DUMMY_W : 6;

  seqStateT           state;
  logic               hiPhase;
  logic [BEAT_W-1:0]  beatsLeft;
  logic [IDX_W-1:0]   byteIdx;
  logic [IDX_W-1:0]   lastIdx;
  logic               writeLat;
  logic [1:0]         instLat;
  logic [1:0]         addrLat;
  logic [1:0]         dataLat;
  logic               addr4Lat;
  logic [DUMMY_W-1:0] dummyLat;

  logic       beatEnd;
  logic       lastBeat;
  logic       lastByte;
  logic       intoData;
  logic       nextByte;
  logic [1:0] dirAddr;
  logic [1:0] dirData;
  logic [1:0] effAddr;
  logic [1:0] effData;

  function automatic logic [BEAT_W-1:0] beatsOf(input int bits, input logic [1:0] code);
    return BEAT_W'(bits >> laneShift(code));
  endfunction

  // multi-lane instruction width takes over the address and data phases
  always_comb begin
    dirAddr = isWrite ? wrAddrWidth : rdAddrWidth;
    dirData = isWrite ? wrDataWidth : rdDataWidth;
    effAddr = (instWidth != 2'd0) ? instWidth : dirAddr;
    effData = (instWidth != 2'd0) ? instWidth : dirData;
  end

  always_comb begin
    beatEnd  = hiPhase && (state == ST_CMD || state == ST_ADDR ||
                           state == ST_DUMMY || state == ST_DATA);
    lastBeat = (beatsLeft == BEAT_W'(1));
    lastByte = (byteIdx == lastIdx);
    intoData = beatEnd && lastBeat &&
               ((state == ST_ADDR && dummyLat == '0) || state == ST_DUMMY);
    nextByte = beatEnd && lastBeat && state == ST_DATA && !lastByte;

    strobe = '0;
    case (state)
      ST_CMD:  strobe.laneCode = instLat;
      ST_ADDR: strobe.laneCode = addrLat;
      default: strobe.laneCode = dataLat;
    endcase
    strobe.drive    = (state == ST_CMD) || (state == ST_ADDR) ||
                      (state == ST_DATA && writeLat);
    strobe.advance  = beatEnd && strobe.drive;
    strobe.sample   = beatEnd && state == ST_DATA && !writeLat;
    strobe.byteEnd  = strobe.sample && lastBeat;
    strobe.loadOp   = (state == ST_IDLE) && start;
    strobe.loadAddr = beatEnd && lastBeat && state == ST_CMD;
    strobe.loadData = writeLat && (intoData || nextByte);
    byteSel         = nextByte ? IDX_W'(byteIdx + 1'b1) : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      csN       <= 1'b1;
      sclk      <= 1'b0;
      hiPhase   <= 1'b0;
      beatsLeft <= '0;
      byteIdx   <= '0;
      lastIdx   <= '0;
      writeLat  <= 1'b0;
      instLat   <= 2'd0;
      addrLat   <= 2'd0;
      dataLat   <= 2'd0;
      addr4Lat  <= 1'b0;
      dummyLat  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state     <= ST_CMD;
            csN       <= 1'b0;
            sclk      <= 1'b0;
            hiPhase   <= 1'b0;
            beatsLeft <= beatsOf(8, instWidth);
            byteIdx   <= '0;
            lastIdx   <= IDX_W'(numBytes - CNT_W'(1));
            writeLat  <= isWrite;
            instLat   <= instWidth;
            addrLat   <= effAddr;
            dataLat   <= effData;
            addr4Lat  <= addr4;
            dummyLat  <= dummyCycles;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: begin
          if (!hiPhase) begin
            sclk    <= 1'b1;
            hiPhase <= 1'b1;
          end else begin
            sclk    <= 1'b0;
            hiPhase <= 1'b0;
            if (!lastBeat) begin
              beatsLeft <= beatsLeft - 1'b1;
            end else begin
              case (state)
                ST_CMD: begin
                  state     <= ST_ADDR;
                  beatsLeft <= beatsOf(addr4Lat ? 32 : 24, addrLat);
                end
                ST_ADDR, ST_DUMMY: begin
                  if (state == ST_ADDR && dummyLat != '0) begin
                    state     <= ST_DUMMY;
                    beatsLeft <= BEAT_W'(dummyLat);
                  end else begin
                    state     <= ST_DATA;
                    beatsLeft <= beatsOf(8, dataLat);
                    byteIdx   <= '0;
                  end
                end
                default: begin
                  if (lastByte) begin
                    state <= ST_DONE;
                    csN   <= 1'b1;
                  end else begin
                    byteIdx   <= byteIdx + 1'b1;
                    beatsLeft <= beatsOf(8, dataLat);
                  end
                end
              endcase
            end
          end
        end
      endcase
    end
  end

  assign busy     = (state != ST_IDLE);
  assign done     = (state == ST_DONE);
  assign stateOut = state;

  a_r9_cs_high_idle: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> csN);

  a_r9_sclk_low_deselected: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DONE) |=> (state == ST_IDLE));

  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && start) |=> ($stable(writeLat) && $stable(lastIdx) && $stable(addrLat)));

endmodule

// File: rtl/fcs_datapath.sv
module fcs_datapath
  import fcs_pkg::*;
#(
  parameter int MAX_BYTES = 4,
  localparam int IDX_W    = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1,
  localparam int DATA_W   = 8 * MAX_BYTES
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobeT          strobe,
  input  logic [IDX_W-1:0]  byteSel,
  input  logic [7:0]        opcode,
  input  logic [31:0]       addr,
  input  logic              addr4,
  input  logic [DATA_W-1:0] wrData,
  input  logic [3:0]        ioIn,
  output logic [3:0]        ioOut,
  output logic [3:0]        ioOe,
  output logic [7:0]        rdByte,
  output logic              rdValid
);

  logic [31:0]       txShift;
  logic [31:0]       addrHold;
  logic [DATA_W-1:0] dataHold;
  logic [7:0]        rxShift;
  logic [7:0]        rxNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift  <= '0;
      addrHold <= '0;
      dataHold <= '0;
    end else if (strobe.loadOp) begin
      txShift  <= {opcode, 24'h0};
      addrHold <= addr4 ? addr : {addr[23:0], 8'h00};
      dataHold <= wrData;
    end else if (strobe.loadAddr) begin
      txShift <= addrHold;
    end else if (strobe.loadData) begin
      txShift <= {dataHold[byteSel*8 +: 8], 24'h0};
    end else if (strobe.advance) begin
      txShift <= txShift << (3'd1 << laneShift(strobe.laneCode));
    end
  end

  always_comb begin
    case (strobe.laneCode)
      2'd0:    ioOut = {3'b000, txShift[31]};
      2'd1:    ioOut = {2'b00, txShift[31:30]};
      default: ioOut = txShift[31:28];
    endcase
    ioOe = strobe.drive ? laneMask(strobe.laneCode) : 4'b0000;
  end

  always_comb begin
    case (strobe.laneCode)
      2'd0:    rxNext = {rxShift[6:0], ioIn[1]};
      2'd1:    rxNext = {rxShift[5:0], ioIn[1:0]};
      default: rxNext = {rxShift[3:0], ioIn};
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      rdByte  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strobe.byteEnd;
      if (strobe.sample) rxShift <= rxNext;
      if (strobe.byteEnd) rdByte <= rxNext;
    end
  end

  a_r2_oe_shape: assert property (@(posedge clk) disable iff (!rstN)
    (ioOe == 4'b0000 || ioOe == 4'b0001 || ioOe == 4'b0011 || ioOe == 4'b1111));

  a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fcs_pkg::*;
#(
  parameter int MAX_BYTES = 4,
  parameter int DUMMY_W   = 4,
  localparam int CNT_W    = $clog2(MAX_BYTES + 1),
  localparam int IDX_W    = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cfgWe,
  input  logic [7:0]             cfgRdOpcode,
  input  logic [7:0]             cfgWrOpcode,
  input  logic [1:0]             cfgInstWidth,
  input  logic [1:0]             cfgRdAddrWidth,
  input  logic [1:0]             cfgRdDataWidth,
  input  logic [1:0]             cfgWrAddrWidth,
  input  logic [1:0]             cfgWrDataWidth,
  input  logic                   cfgAddr4Byte,
  input  logic [DUMMY_W-1:0]     cfgDummyCycles,
  input  logic                   start,
  input  logic                   isWrite,
  input  logic [31:0]            addr,
  input  logic [CNT_W-1:0]       numBytes,
  input  logic [8*MAX_BYTES-1:0] wrData,
  input  logic [3:0]             ioIn,
  output logic                   sclk,
  output logic                   csN,
  output logic [3:0]             ioOut,
  output logic [3:0]             ioOe,
  output logic [7:0]             rdByte,
  output logic                   rdValid,
  output logic                   done,
  output logic                   busy
);

  logic [7:0]         rdOp, wrOp;
  logic [1:0]         instWidth, rdAddrWidth, rdDataWidth, wrAddrWidth, wrDataWidth;
  logic               addr4;
  logic [DUMMY_W-1:0] dummyCycles;
  dpStrobeT           strobe;
  logic [IDX_W-1:0]   byteSel;
  seqStateT           ctrlState;
  logic [7:0]         opcodeSel;

  assign opcodeSel = isWrite ? wrOp : rdOp;

  fcs_cfg #(.DUMMY_W(DUMMY_W)) u_cfg (
    .clk(clk), .rstN(rstN), .busy(busy), .cfgWe(cfgWe),
    .rdOpIn(cfgRdOpcode), .wrOpIn(cfgWrOpcode), .instIn(cfgInstWidth),
    .rdAddrIn(cfgRdAddrWidth), .rdDataIn(cfgRdDataWidth),
    .wrAddrIn(cfgWrAddrWidth), .wrDataIn(cfgWrDataWidth),
    .addr4In(cfgAddr4Byte), .dummyIn(cfgDummyCycles),
    .rdOp(rdOp), .wrOp(wrOp), .instWidth(instWidth),
    .rdAddrWidth(rdAddrWidth), .rdDataWidth(rdDataWidth),
    .wrAddrWidth(wrAddrWidth), .wrDataWidth(wrDataWidth),
    .addr4(addr4), .dummyCycles(dummyCycles)
  );

  fcs_ctrl #(.MAX_BYTES(MAX_BYTES), .DUMMY_W(DUMMY_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .isWrite(isWrite), .numBytes(numBytes),
    .instWidth(instWidth), .rdAddrWidth(rdAddrWidth), .rdDataWidth(rdDataWidth),
    .wrAddrWidth(wrAddrWidth), .wrDataWidth(wrDataWidth), .addr4(addr4),
    .dummyCycles(dummyCycles), .sclk(sclk), .csN(csN), .busy(busy), .done(done),
    .strobe(strobe), .byteSel(byteSel), .stateOut(ctrlState)
  );

  fcs_datapath #(.MAX_BYTES(MAX_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .byteSel(byteSel), .opcode(opcodeSel),
    .addr(addr), .addr4(addr4), .wrData(wrData), .ioIn(ioIn),
    .ioOut(ioOut), .ioOe(ioOe), .rdByte(rdByte), .rdValid(rdValid)
  );

  a_r6_dummy_tristate: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == ST_DUMMY) |-> (ioOe == 4'b0000));

  a_r9_lanes_quiet_deselected: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> (ioOe == 4'b0000));

endmodule

// File: tb/flash_cmd_seq_tb.sv
module flash_cmd_seq_tb;

  localparam int MAX_BYTES = 4;
  localparam int DUMMY_W   = 4;
  localparam int CNT_W     = 3;

  logic clk = 1'b0;
  logic rstN;
  logic cfgWe;
  logic [7:0] cfgRdOpcode, cfgWrOpcode;
  logic [1:0] cfgInstWidth, cfgRdAddrWidth, cfgRdDataWidth, cfgWrAddrWidth, cfgWrDataWidth;
  logic cfgAddr4Byte;
  logic [DUMMY_W-1:0] cfgDummyCycles;
  logic start, isWrite;
  logic [31:0] addr;
  logic [CNT_W-1:0] numBytes;
  logic [8*MAX_BYTES-1:0] wrData;
  logic [3:0] ioIn;
  logic sclk, csN, rdValid, done, busy;
  logic [3:0] ioOut, ioOe;
  logic [7:0] rdByte;

  flash_cmd_seq #(.MAX_BYTES(MAX_BYTES), .DUMMY_W(DUMMY_W)) u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgRdOpcode(cfgRdOpcode),
    .cfgWrOpcode(cfgWrOpcode), .cfgInstWidth(cfgInstWidth),
    .cfgRdAddrWidth(cfgRdAddrWidth), .cfgRdDataWidth(cfgRdDataWidth),
    .cfgWrAddrWidth(cfgWrAddrWidth), .cfgWrDataWidth(cfgWrDataWidth),
    .cfgAddr4Byte(cfgAddr4Byte), .cfgDummyCycles(cfgDummyCycles),
    .start(start), .isWrite(isWrite), .addr(addr), .numBytes(numBytes),
    .wrData(wrData), .ioIn(ioIn), .sclk(sclk), .csN(csN), .ioOut(ioOut),
    .ioOe(ioOe), .rdByte(rdByte), .rdValid(rdValid), .done(done), .busy(busy)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  int txnCnt = 0;

  logic [3:0] outLog [0:127];
  logic [3:0] oeLog  [0:127];
  logic [7:0] got    [0:7];
  int beat, csLow, doneCnt, doneCsHigh, nGot;
  bit prevSclk;
  bit expRead;
  int dStart, ldG, nbExp;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int lanesOf(input int code);
    return (code == 0) ? 1 : (code == 1) ? 2 : 4;
  endfunction

  function automatic logic [3:0] maskOf(input int lanes);
    return 4'((1 << lanes) - 1);
  endfunction

  function automatic logic [7:0] rdPat(input int k);
    return 8'h5A ^ 8'(k * 59) ^ 8'(txnCnt);
  endfunction

  function automatic logic [31:0] assemble(input int s, input int n, input int lanes);
    logic [31:0] v = '0;
    for (int i = 0; i < n; i++) begin
      case (lanes)
        1:       v = {v[30:0], outLog[s+i][0]};
        2:       v = {v[29:0], outLog[s+i][1:0]};
        default: v = {v[27:0], outLog[s+i]};
      endcase
    end
    return v;
  endfunction

  function automatic bit oeAll(input int s, input int n, input logic [3:0] m);
    for (int i = 0; i < n; i++) if (oeLog[s+i] !== m) return 0;
    return 1;
  endfunction

  task automatic observe();
    if (!csN && sclk && !prevSclk) begin
      if (beat < 128) begin
        outLog[beat] = ioOut;
        oeLog[beat]  = ioOe;
      end
      beat++;
    end
    if (!csN) csLow++;
    if (!csN && !sclk) begin
      int bpb = 8 / ldG;
      if (expRead && beat >= dStart && beat < dStart + nbExp * bpb) begin
        int j = beat - dStart;
        int k = j / bpb;
        int p = j % bpb;
        logic [7:0] sh = rdPat(k) >> (8 - ldG * (p + 1));
        case (ldG)
          1:       ioIn = {~sh[0], ~sh[0], sh[0], ~sh[0]};
          2:       ioIn = {~sh[1:0], sh[1:0]};
          default: ioIn = sh[3:0];
        endcase
      end else begin
        ioIn = 4'b1010;
      end
    end
    if (rdValid) begin
      if (nGot < 8) got[nGot] = rdByte;
      nGot++;
    end
    if (done) begin
      doneCnt++;
      if (csN) doneCsHigh++;
    end
    prevSclk = sclk;
  endtask

  task automatic setCfg(input logic [7:0] rop, input logic [7:0] wop, input int inst,
                        input int ra, input int rd, input int wa, input int wd,
                        input bit a4, input int dum);
    @(negedge clk);
    cfgRdOpcode = rop; cfgWrOpcode = wop; cfgInstWidth = 2'(inst);
    cfgRdAddrWidth = 2'(ra); cfgRdDataWidth = 2'(rd);
    cfgWrAddrWidth = 2'(wa); cfgWrDataWidth = 2'(wd);
    cfgAddr4Byte = a4; cfgDummyCycles = DUMMY_W'(dum);
    cfgWe = 1'b1;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic runTxn(input bit wr, input logic [31:0] a, input int nb,
                        input logic [31:0] wd, input logic [7:0] op, input int instC,
                        input int aC, input int dC, input bit a4, input int dum,
                        input bit poke);
    int li = lanesOf(instC);
    int la = (instC != 0) ? li : lanesOf(aC);
    int ld = (instC != 0) ? li : lanesOf(dC);
    int ob = 8 / li;
    int ab = (a4 ? 32 : 24) / la;
    int bpb = 8 / ld;
    int db = nb * bpb;
    int total = ob + ab + dum + db;
    int it = 0;
    logic [31:0] expA = a4 ? a : {8'h00, a[23:0]};
    txnCnt++;
    expRead = !wr; dStart = ob + ab + dum; ldG = ld; nbExp = nb;
    beat = 0; csLow = 0; doneCnt = 0; doneCsHigh = 0; nGot = 0; prevSclk = 0;
    @(negedge clk);
    start = 1'b1; isWrite = wr; addr = a; numBytes = CNT_W'(nb); wrData = wd;
    @(negedge clk);
    start = 1'b0;
    observe();
    while (!(doneCnt > 0 && !busy) && it < 1000) begin
      @(negedge clk);
      if (poke && it == 6) begin
        start = 1'b1; isWrite = !wr; addr = ~a; numBytes = CNT_W'(1);
        cfgWe = 1'b1; cfgRdOpcode = 8'hFF; cfgWrOpcode = 8'hFF; cfgInstWidth = 2'd2;
        cfgDummyCycles = DUMMY_W'(9);
      end else if (poke && it == 7) begin
        start = 1'b0; cfgWe = 1'b0;
      end
      observe();
      it++;
    end
    check(it < 1000, "R9 command completes", 32'(it), 32'(total));
    // R9: one serial clock is two system clocks with csN low
    check(beat == total && csLow == 2 * total, "R9 beat count and cs window",
          32'(csLow), 32'(2 * total));
    // R3: opcode on the shared instruction width
    check(assemble(0, ob, li) == {24'h0, op}, "R3 opcode bits", assemble(0, ob, li), {24'h0, op});
    check(oeAll(0, ob, maskOf(li)), "R2 opcode lane enables", 32'(oeLog[0]), 32'(maskOf(li)));
    // R5 with R4 override of width
    check(assemble(ob, ab, la) == expA, "R5 address bits (R4 width)", assemble(ob, ab, la), expA);
    check(oeAll(ob, ab, maskOf(la)), "R2 address lane enables", 32'(oeLog[ob]), 32'(maskOf(la)));
    if (dum > 0)
      check(oeAll(ob + ab, dum, 4'b0000), "R6 dummy tristate", 32'(oeLog[ob+ab]), 32'h0);
    if (wr) begin
      for (int k = 0; k < nb; k++) begin
        logic [31:0] gb = assemble(dStart + k * bpb, bpb, ld);
        check(gb == {24'h0, wd[8*k +: 8]}, "R8 write byte", gb, {24'h0, wd[8*k +: 8]});
      end
      check(oeAll(dStart, db, maskOf(ld)), "R8 data lane enables", 32'(oeLog[dStart]), 32'(maskOf(ld)));
    end else begin
      check(nGot == nb, "R7 received byte count", 32'(nGot), 32'(nb));
      for (int k = 0; k < nb && k < nGot; k++)
        check(got[k] == rdPat(k), "R7 read byte", 32'(got[k]), 32'(rdPat(k)));
      check(oeAll(dStart, db, 4'b0000), "R7 data tristate", 32'(oeLog[dStart]), 32'h0);
    end
    check(doneCnt == 1 && doneCsHigh == 1, "R9 done pulse after cs release",
          32'(doneCnt), 32'h1);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish actual=hung expected=complete");
      summary();
    end
  end

  initial begin
    int cnt = 0;
    rstN = 1'b0; cfgWe = 1'b0; start = 1'b0; isWrite = 1'b0; addr = '0;
    numBytes = '0; wrData = '0; ioIn = '0;
    cfgRdOpcode = '0; cfgWrOpcode = '0; cfgInstWidth = '0; cfgRdAddrWidth = '0;
    cfgRdDataWidth = '0; cfgWrAddrWidth = '0; cfgWrDataWidth = '0;
    cfgAddr4Byte = 1'b0; cfgDummyCycles = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: idle outputs after reset
    check(csN && !sclk && ioOe == 4'b0 && !busy && !done && !rdValid,
          "R1 reset outputs", {26'h0, csN, sclk, busy, done, rdValid, 1'b0}, 32'h20);
    // R1: default read and write commands, single lane, 3-byte address
    runTxn(1'b0, 32'h00A1B2C3, 2, 32'h0, 8'h03, 0, 0, 0, 1'b0, 0, 1'b0);
    runTxn(1'b1, 32'h00123456, 3, 32'h00C3B2A1, 8'h02, 0, 0, 0, 1'b0, 0, 1'b0);

    // R2 R3 R4 R5 R6 R7 R8: sweep of every width combination per direction
    for (int inst = 0; inst < 3; inst++)
      for (int aw = 0; aw < 3; aw++)
        for (int dw = 0; dw < 3; dw++)
          for (int a4 = 0; a4 < 2; a4++) begin
            logic [7:0] rop = 8'h0B + 8'(cnt);
            logic [7:0] wop = 8'h32 ^ 8'(cnt);
            int dum = (cnt % 4) * 5;
            int nb = (cnt % MAX_BYTES) + 1;
            int wa = (aw + 1) % 3;
            int wdc = (dw + 2) % 3;
            setCfg(rop, wop, inst, aw, dw, wa, wdc, a4[0], dum);
            runTxn(1'b0, 32'hC0DE0000 + 32'(cnt * 4099), nb, 32'h0, rop,
                   inst, aw, dw, a4[0], dum, 1'b0);
            runTxn(1'b1, 32'h5EED0000 ^ 32'(cnt * 7919), nb, 32'h8E3F_7A19 ^ 32'(cnt * 101),
                   wop, inst, wa, wdc, a4[0], dum, 1'b0);
            cnt++;
          end

    // R10 R11: start and cfgWe during a command have no effect
    setCfg(8'h6B, 8'h12, 0, 1, 2, 0, 0, 1'b0, 2);
    runTxn(1'b0, 32'h00ABCDEF, 4, 32'h0, 8'h6B, 0, 1, 2, 1'b0, 2, 1'b1);
    repeat (6) begin
      @(negedge clk);
      check(csN && !busy, "R10 no second command from ignored start",
            {30'h0, csN, busy}, 32'h2);
    end
    // R11: the configuration in force is still the earlier one
    runTxn(1'b0, 32'h00135790, 1, 32'h0, 8'h6B, 0, 1, 2, 1'b0, 2, 1'b0);
    runTxn(1'b1, 32'h00246801, 2, 32'h0000_9F6C, 8'h12, 0, 0, 0, 1'b0, 2, 1'b0);
    summary();
  end

endmodule